// File: doc/BRIEF.md
# Check-Bit Compaction Switch Network

This block sits between an error-correcting code generator that always produces its full set of check bits and a memory array that stores only the check bits a given chip actually uses. Each check bit corresponds to one row of the parity-check matrix. After the memory is tested, a per-chip enable vector records which rows stay active. That test can run at manufacturing time or at boot.

On the write path, the block gathers the enabled check bits and places them into a narrow storage field. The enabled bits take the low storage slots in ascending index order, leaving no gaps. On the read path, the same enable vector steers the stored field back out to the full-width positions the decoder expects. Disabled positions read as zero, and the decoder masks them.

Both paths are purely combinational. The only register is the enable vector. It changes only while a load strobe is asserted. The block also reports how many rows are enabled, and it flags any write whose enabled set does not fit the storage width.

Top module: `ckc_switch_net`

## Requirements
- R1: After reset the enable vector is all zero, so the enabled count is 0 and the packed and expanded outputs are all zero.
- R2: The enable vector takes the value of `cfg_in` at a rising clock edge where `cfg_load` is 1. With `cfg_load` at 0 it keeps its value, whatever `cfg_in` carries.
- R3: `en_count` equals the number of 1 bits in the current enable vector; bit i of the vector enables check-bit position i.
- R4: Let the enabled positions be taken in ascending index order, and let k be the rank of a position in that order (k = 0, 1, …). The enabled position of rank k drives `chk_packed_out[k]` with its `chk_full_in` bit, for every k below STORE_W.
- R5: Every bit of `chk_packed_out` at index `en_count` or above is zero.
- R6: An enabled position i whose rank r is below STORE_W drives `chk_full_out[i]` with `chk_stored_in[r]`.
- R7: Every disabled position of `chk_full_out` is zero.
- R8: An enabled position whose rank is STORE_W or higher reads zero on `chk_full_out`.
- R9: `ovf_err` is 1 exactly when `wr_en` is 1 and `en_count` exceeds STORE_W.
- R10: Feeding `chk_packed_out` back into `chk_stored_in` makes `chk_full_out` equal `chk_full_in` masked by the enable vector, whenever `en_count` is at most STORE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the enable vector |
| cfg_in | input | FULL_W | New enable vector |
| wr_en | input | 1 | Marks a write in progress, for the overflow flag |
| chk_full_in | input | FULL_W | Full check-bit vector from the generator |
| chk_packed_out | output | STORE_W | Compacted check bits toward storage |
| chk_stored_in | input | STORE_W | Compacted check bits read from storage |
| chk_full_out | output | FULL_W | Expanded check bits toward the decoder |
| en_count | output | $clog2(FULL_W+1) | Number of enabled rows |
| ovf_err | output | 1 | Enabled set too large for storage during a write |

## Verification
The assertions assume that `cfg_in` and `cfg_load` are clean at the clock edge. They also assume that STORE_W does not exceed FULL_W, so the count comparison is meaningful.

The stimulus changes inputs only near the falling edge. It loads each new enable vector only when it means to, and it also applies strobe-free cycles with a different `cfg_in` value to show that the vector holds.

The enable vectors cover several cases:
- empty and full vectors;
- sets that fit the storage exactly, or exceed it by one;
- alternating patterns;
- random patterns.

Loopback is tested both within and beyond the storage limit.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  // Width needed to hold a count from 0 to n inclusive.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ckc_cfg_reg.sv
module ckc_cfg_reg #(
  parameter int FULL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FULL_W-1:0] d_in,
  output logic [FULL_W-1:0] q_out
);
  logic [FULL_W-1:0] cfg_d;
  logic [FULL_W-1:0] cfg_q;

  // Next state: the clock enable is written out explicitly.
  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign q_out = cfg_q;
endmodule

// File: rtl/ckc_rank.sv
module ckc_rank #(
  parameter int FULL_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [FULL_W-1:0]            en,
  output logic [FULL_W-1:0][CNT_W-1:0] rank,
  output logic [CNT_W-1:0]             total
);
  // pre[i] counts the enabled positions strictly below i.
  logic [FULL_W:0][CNT_W-1:0] pre;

  assign pre[0] = '0;

  for (genvar i = 0; i < FULL_W; i++) begin : g_prefix
    assign pre[i+1] = pre[i] + CNT_W'(en[i]);
    assign rank[i]  = pre[i];
  end

  assign total = pre[FULL_W];
endmodule

// File: rtl/ckc_pack.sv
module ckc_pack #(
  parameter int FULL_W  = 16,
  parameter int STORE_W = 10,
  parameter int CNT_W   = 5
) (
  input  logic [FULL_W-1:0]            en,
  input  logic [FULL_W-1:0][CNT_W-1:0] rank,
  input  logic [FULL_W-1:0]            din,
  output logic [STORE_W-1:0]           dout
);
  // One OR-of-selects per storage slot: slot k takes the enabled bit of rank k.
  for (genvar k = 0; k < STORE_W; k++) begin : g_slot
    logic slot_v;
    always_comb begin
      slot_v = 1'b0;
      for (int i = 0; i < FULL_W; i++) begin
        if (en[i] && (rank[i] == CNT_W'(k))) slot_v = slot_v | din[i];
      end
    end
    assign dout[k] = slot_v;
  end
endmodule

// File: rtl/ckc_unpack.sv
module ckc_unpack #(
  parameter int FULL_W  = 16,
  parameter int STORE_W = 10,
  parameter int CNT_W   = 5
) (
  input  logic [FULL_W-1:0]            en,
  input  logic [FULL_W-1:0][CNT_W-1:0] rank,
  input  logic [STORE_W-1:0]           sin,
  output logic [FULL_W-1:0]            dout
);
  // Each full-width position picks the stored slot at its rank, or zero.
  for (genvar i = 0; i < FULL_W; i++) begin : g_pos
    logic pos_v;
    always_comb begin
      pos_v = 1'b0;
      for (int r = 0; r < STORE_W; r++) begin
        if (en[i] && (rank[i] == CNT_W'(r))) pos_v = sin[r];
      end
    end
    assign dout[i] = pos_v;
  end
endmodule

// File: rtl/ckc_switch_net.sv
module ckc_switch_net #(
  parameter int FULL_W  = 16,
  parameter int STORE_W = 10
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_load,
  input  logic [FULL_W-1:0]                      cfg_in,
  input  logic                                   wr_en,
  input  logic [FULL_W-1:0]                      chk_full_in,
  output logic [STORE_W-1:0]                     chk_packed_out,
  input  logic [STORE_W-1:0]                     chk_stored_in,
  output logic [FULL_W-1:0]                      chk_full_out,
  output logic [ckc_pkg::cnt_width(FULL_W)-1:0]  en_count,
  output logic                                   ovf_err
);
  localparam int CNT_W = ckc_pkg::cnt_width(FULL_W);

  logic [FULL_W-1:0]            cfg_q;
  logic [FULL_W-1:0][CNT_W-1:0] rank;
  logic [CNT_W-1:0]             total;

  ckc_cfg_reg #(.FULL_W(FULL_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .d_in  (cfg_in),
    .q_out (cfg_q)
  );

  ckc_rank #(.FULL_W(FULL_W), .CNT_W(CNT_W)) u_rank (
    .en    (cfg_q),
    .rank  (rank),
    .total (total)
  );

  ckc_pack #(.FULL_W(FULL_W), .STORE_W(STORE_W), .CNT_W(CNT_W)) u_pack (
    .en   (cfg_q),
    .rank (rank),
    .din  (chk_full_in),
    .dout (chk_packed_out)
  );

  ckc_unpack #(.FULL_W(FULL_W), .STORE_W(STORE_W), .CNT_W(CNT_W)) u_unpack (
    .en   (cfg_q),
    .rank (rank),
    .sin  (chk_stored_in),
    .dout (chk_full_out)
  );

  assign en_count = total;
  assign ovf_err  = wr_en && (total > CNT_W'(STORE_W));
endmodule

// File: rtl/ckc_switch_net_chk.sv
module ckc_switch_net_chk #(
  parameter int FULL_W  = 16,
  parameter int STORE_W = 10,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_load,
  input logic [FULL_W-1:0]  cfg_in,
  input logic [FULL_W-1:0]  cfg_q,
  input logic [FULL_W-1:0]  chk_full_in,
  input logic [STORE_W-1:0] chk_packed_out,
  input logic [FULL_W-1:0]  chk_full_out,
  input logic [CNT_W-1:0]   en_count,
  input logic               ovf_err
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(en_count));

  p_load_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (int'(en_count) == $countones($past(cfg_in))));

  p_packed_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chk_packed_out) <= $countones(chk_full_in & cfg_q));

  p_packed_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cfg_q) <= STORE_W) |->
      ($countones(chk_packed_out) == $countones(chk_full_in & cfg_q)));

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((chk_full_out & ~cfg_q) == '0));

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> ($countones(cfg_q) > STORE_W));
endmodule

bind ckc_switch_net ckc_switch_net_chk #(
  .FULL_W  (FULL_W),
  .STORE_W (STORE_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_load       (cfg_load),
  .cfg_in         (cfg_in),
  .cfg_q          (cfg_q),
  .chk_full_in    (chk_full_in),
  .chk_packed_out (chk_packed_out),
  .chk_full_out   (chk_full_out),
  .en_count       (en_count),
  .ovf_err        (ovf_err)
);

// File: tb/tb_ckc_switch_net.sv
`timescale 1ns/1ps
module tb_ckc_switch_net;
  localparam int FW = 16;
  localparam int SW = 10;
  localparam int CW = $clog2(FW + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [FW-1:0] cfg_in;
  logic          wr_en;
  logic [FW-1:0] chk_full_in;
  logic [SW-1:0] chk_packed_out;
  logic [SW-1:0] chk_stored_in;
  logic [FW-1:0] chk_full_out;
  logic [CW-1:0] en_count;
  logic          ovf_err;

  int vecs  = 0;
  int fails = 0;
  logic [FW-1:0] m_cfg;   // reference model of the enable vector

  always #4 clk = ~clk;   // 125 MHz

  ckc_switch_net #(.FULL_W(FW), .STORE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in),
    .wr_en(wr_en), .chk_full_in(chk_full_in), .chk_packed_out(chk_packed_out),
    .chk_stored_in(chk_stored_in), .chk_full_out(chk_full_out),
    .en_count(en_count), .ovf_err(ovf_err)
  );

  function automatic int ones(input logic [FW-1:0] v);
    int n = 0;
    for (int i = 0; i < FW; i++) n += int'(v[i]);
    return n;
  endfunction

  // Behavioural pack: walk enabled positions with a running slot pointer.
  function automatic logic [SW-1:0] ref_pack(input logic [FW-1:0] en, input logic [FW-1:0] d);
    logic [SW-1:0] r = '0;
    int slot = 0;
    for (int i = 0; i < FW; i++) begin
      if (en[i]) begin
        if (slot < SW) r[slot] = d[i];
        slot++;
      end
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] ref_unpack(input logic [FW-1:0] en, input logic [SW-1:0] s);
    logic [FW-1:0] r = '0;
    int slot = 0;
    for (int i = 0; i < FW; i++) begin
      if (en[i]) begin
        if (slot < SW) r[i] = s[slot];
        slot++;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One vector: drive at the falling edge, check away from the edge, then advance the model.
  task automatic apply(input bit load, input logic [FW-1:0] cfg, input bit we,
                       input logic [FW-1:0] din, input logic [SW-1:0] sin);
    logic [SW-1:0] pk;
    logic [FW-1:0] mask_in;
    @(negedge clk);
    cfg_load = load; cfg_in = cfg; wr_en = we;
    chk_full_in = din; chk_stored_in = sin;
    #1;
    chk(int'(en_count) == ones(m_cfg), "R3", "en_count", 32'(en_count), 32'(ones(m_cfg)));
    pk = ref_pack(m_cfg, din);
    chk(chk_packed_out == pk, "R4/R5", "packed", 32'(chk_packed_out), 32'(pk));
    chk(chk_full_out == ref_unpack(m_cfg, sin), "R6/R7/R8", "expanded",
        32'(chk_full_out), 32'(ref_unpack(m_cfg, sin)));
    chk(ovf_err == (we && ones(m_cfg) > SW), "R9", "ovf_err",
        32'(ovf_err), 32'(we && ones(m_cfg) > SW));
    // Loopback: storage fed from the packed output.
    chk_stored_in = chk_packed_out;
    #1;
    mask_in = din & m_cfg;
    if (ones(m_cfg) <= SW)
      chk(chk_full_out == mask_in, "R10", "roundtrip", 32'(chk_full_out), 32'(mask_in));
    else
      chk(chk_full_out == ref_unpack(m_cfg, ref_pack(m_cfg, din)), "R8", "roundtrip overflow",
          32'(chk_full_out), 32'(ref_unpack(m_cfg, ref_pack(m_cfg, din))));
    @(posedge clk);
    if (load) m_cfg = cfg;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [FW-1:0] c;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_in = '1; wr_en = 1'b1;
    chk_full_in = '1; chk_stored_in = '1;
    m_cfg = '0;
    #3;
    // R1: reset state with all-ones data at the inputs.
    chk(en_count == '0, "R1", "count in reset", 32'(en_count), 0);
    chk(chk_packed_out == '0, "R1", "packed in reset", 32'(chk_packed_out), 0);
    chk(chk_full_out == '0, "R1", "expanded in reset", 32'(chk_full_out), 0);
    chk(ovf_err == 1'b0, "R1", "ovf in reset", 32'(ovf_err), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    apply(1'b0, 16'hFFFF, 1'b1, 16'hA5A5, 10'h3FF);  // R2: no load, vector stays empty
    apply(1'b1, 16'hFFFF, 1'b1, 16'h1234, 10'h155);  // load all ones
    apply(1'b0, 16'h0001, 1'b1, 16'hBEEF, 10'h2AA);  // R9 overflow; R2 hold
    apply(1'b0, 16'h0000, 1'b0, 16'hBEEF, 10'h2AA);  // wr_en low, no flag
    apply(1'b1, 16'h03FF, 1'b1, 16'hFFFF, 10'h0F0);  // exactly fits
    apply(1'b1, 16'h07FF, 1'b1, 16'h5A5A, 10'h3C3);  // one over
    apply(1'b1, 16'hAAAA, 1'b1, 16'hCAFE, 10'h1B6);  // alternating
    apply(1'b1, 16'h5555, 1'b0, 16'h0F0F, 10'h36C);
    apply(1'b1, 16'h8001, 1'b1, 16'hFFFF, 10'h001);  // extremes
    apply(1'b1, 16'h0000, 1'b1, 16'hFFFF, 10'h3FF);  // empty: R7 all zero
    for (int n = 0; n < 400; n++) begin
      c = FW'($urandom);
      if (n % 3 == 0) c = c & FW'($urandom);         // bias toward fitting sets
      apply(($urandom % 4) != 0, c, 1'($urandom), FW'($urandom), SW'($urandom));
    end
    finish_run();
  end
endmodule